// File: doc/BRIEF.md
# Extended State Save Mask Unit

This block keeps two enable registers that decide which groups of processor state a save or restore may touch. The feature control register can be read by any caller and written only at privilege 0. Each of its bits enables one state component and also lets that component's instructions execute. The supervisor state register is reached only through the model-specific register space, at address 0xDA0, and only at privilege 0.

A save or restore request carries a requested-component bitmap and a type, user or supervisor. For a user-type request, the block ANDs the feature control register with the bitmap. For a supervisor-type request, it ANDs the union of both registers with the bitmap. It also checks every register access. An illegal access raises a one-cycle fault and leaves both registers unchanged. Moving the state to or from memory is the job of another unit.

The access port serves both spaces. A select input picks the feature control space, where the address is a register index and only index 0 exists, or the model-specific space, where the address is the 16-bit register address.

Top module: `xstate_mask_unit`

## Requirements
- R1: After reset, the feature control register holds 0x01 and the supervisor register holds 0x00. The outputs read: `feat_en_o` = 0x01, `mask_o` = 0, `fault_o` = 0, `rdata_o` = 0.
- R2: A write to feature control index 0 at privilege 0 stores the written value, provided bit 0 is set and only bits 0..3 are set. A read of index 0 returns the stored value at any privilege from 0 to 3.
- R3: A feature control write at privilege 1, 2 or 3 faults and changes nothing.
- R4: A feature control read or write at any index other than 0 faults, returns 0 and changes nothing.
- R5: A feature control write with bit 0 clear faults and changes nothing. Bit 0 of that register therefore always reads 1.
- R6: A write that sets a reserved bit faults and changes nothing. Bits 4..7 are reserved in the feature control register. All bits except 4 and 5 are reserved in the supervisor register.
- R7: The supervisor register is read and written through the model-specific space at address 0xDA0 at privilege 0. Any model-specific access at another address or at a non-zero privilege faults and changes nothing.
- R8: `feat_en_o` equals the feature control register, starting in the cycle after a write.
- R9: A user-type request (`save_sup_i` = 0) sets `mask_o` to the feature control register ANDed with `save_rfbm_i`. If component A is enabled only in feature control and component B only in the supervisor register, a user request with all bits requested covers A alone. `mask_o` holds its value until the next request.
- R10: A supervisor-type request (`save_sup_i` = 1) sets `mask_o` to (feature control OR supervisor register) ANDed with `save_rfbm_i`. In the same A and B case, it covers both A and B.
- R11: `fault_o` is high for exactly the one cycle after a faulting access. `rdata_o` shows the read value in the cycle after a legal read, and 0 after any other access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_en_i | input | 1 | Register access valid |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_msr_i | input | 1 | 1 = model-specific space, 0 = feature control index space |
| acc_addr_i | input | 16 | Register index or model-specific address |
| acc_priv_i | input | 2 | Privilege level of the access, 0 = most privileged |
| acc_wdata_i | input | 8 | Write data |
| save_req_i | input | 1 | Save/restore request |
| save_sup_i | input | 1 | Request type, 1 = supervisor |
| save_rfbm_i | input | 8 | Requested-component bitmap |
| mask_o | output | 8 | Effective component bitmap |
| rdata_o | output | 8 | Read data |
| fault_o | output | 1 | General-protection fault pulse |
| feat_en_o | output | 8 | Per-feature instruction enables |

## Verification
Fault, read data and mask are all registered, so each one is due exactly one clock after the access or request that causes it. `feat_en_o` follows the register with no further delay, so a new value also shows one clock after the write. The bench drives inputs on the falling edge and waits through exactly one rising edge. It then samples every output on the next falling edge. Each rejected write is followed by a legal read of the same register, which shows through the port that nothing changed.

// File: rtl/xstate_pkg.sv
package xstate_pkg;
  localparam logic [15:0] SUP_MSR_ADDR = 16'h0DA0;

  typedef struct packed {
    logic fault;
    logic wr_xcr;
    logic wr_xss;
    logic rd_xcr;
    logic rd_xss;
  } acc_dec_t;
endpackage

// File: rtl/xstate_access_check.sv
module xstate_access_check
  import xstate_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [W-1:0] USER_OK = 8'h0F,
  parameter logic [W-1:0] SUP_OK = 8'h30
) (
  input  logic          en_i,
  input  logic          we_i,
  input  logic          msr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    priv_i,
  input  logic [W-1:0]  wdata_i,
  output acc_dec_t      dec_o
);
  localparam logic [AW-1:0] MSR_A = AW'(SUP_MSR_ADDR);

  logic priv_ok, xcr_rsvd, xss_rsvd;
  assign priv_ok  = (priv_i == 2'd0);
  assign xcr_rsvd = |(wdata_i & ~USER_OK);
  assign xss_rsvd = |(wdata_i & ~SUP_OK);

  always_comb begin
    dec_o = '0;
    if (en_i) begin
      if (!msr_i) begin
        if (addr_i != '0)                                     dec_o.fault  = 1'b1;
        else if (!we_i)                                       dec_o.rd_xcr = 1'b1;
        else if (!priv_ok || !wdata_i[0] || xcr_rsvd)         dec_o.fault  = 1'b1;
        else                                                  dec_o.wr_xcr = 1'b1;
      end else begin
        if (!priv_ok || addr_i != MSR_A)                      dec_o.fault  = 1'b1;
        else if (!we_i)                                       dec_o.rd_xss = 1'b1;
        else if (xss_rsvd)                                    dec_o.fault  = 1'b1;
        else                                                  dec_o.wr_xss = 1'b1;
      end
    end
  end

  // at most one action per access
  always_comb begin
    assert ($onehot0({dec_o.fault, dec_o.wr_xcr, dec_o.wr_xss, dec_o.rd_xcr, dec_o.rd_xss}))
      else $error("p_one_action_r11");
  end
endmodule

// File: rtl/xstate_regs.sv
module xstate_regs
  import xstate_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] SUP_OK = 8'h30
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  acc_dec_t     dec_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] xcr_o,
  output logic [W-1:0] xss_o,
  output logic [W-1:0] rdata_o,
  output logic         fault_o
);
  localparam logic [W-1:0] XCR_RST = W'(1);

  logic [W-1:0] xcr_q, xss_q, rdata_q;
  logic         fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xcr_q   <= XCR_RST;
      xss_q   <= '0;
      rdata_q <= '0;
      fault_q <= 1'b0;
    end else begin
      if (dec_i.wr_xcr) xcr_q <= wdata_i;
      if (dec_i.wr_xss) xss_q <= wdata_i;
      fault_q <= dec_i.fault;
      rdata_q <= dec_i.rd_xcr ? xcr_q : (dec_i.rd_xss ? xss_q : '0);
    end
  end

  assign xcr_o   = xcr_q;
  assign xss_o   = xss_q;
  assign rdata_o = rdata_q;
  assign fault_o = fault_q;

  p_xcr_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(xcr_q) |-> $past(dec_i.wr_xcr));
  p_xss_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(xss_q) |-> $past(dec_i.wr_xss));
  p_base_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni) xcr_q[0]);
  p_xss_rsvd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xss_q & ~SUP_OK) == '0);
endmodule

// File: rtl/xstate_mask_gen.sv
module xstate_mask_gen #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic         sup_i,
  input  logic [W-1:0] rfbm_i,
  input  logic [W-1:0] xcr_i,
  input  logic [W-1:0] xss_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] sel, mask_q;

  assign sel = sup_i ? (xcr_i | xss_i) : xcr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_q <= '0;
    else if (req_i) mask_q <= sel & rfbm_i;
  end

  assign mask_o = mask_q;

  p_user_subset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !sup_i) |=> (mask_q & ~$past(xcr_i)) == '0);
  p_sup_subset_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (mask_q & ~$past(rfbm_i)) == '0);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(mask_q));
endmodule

// File: rtl/xstate_mask_unit.sv
module xstate_mask_unit
  import xstate_pkg::*;
#(
  parameter int W = 8,
  parameter int AW = 16,
  parameter logic [W-1:0] USER_OK = 8'h0F,
  parameter logic [W-1:0] SUP_OK = 8'h30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_en_i,
  input  logic          acc_we_i,
  input  logic          acc_msr_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic [1:0]    acc_priv_i,
  input  logic [W-1:0]  acc_wdata_i,
  input  logic          save_req_i,
  input  logic          save_sup_i,
  input  logic [W-1:0]  save_rfbm_i,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  rdata_o,
  output logic          fault_o,
  output logic [W-1:0]  feat_en_o
);
  acc_dec_t     dec;
  logic [W-1:0] xcr, xss;

  xstate_access_check #(.W(W), .AW(AW), .USER_OK(USER_OK), .SUP_OK(SUP_OK)) u_chk (
    .en_i(acc_en_i), .we_i(acc_we_i), .msr_i(acc_msr_i), .addr_i(acc_addr_i),
    .priv_i(acc_priv_i), .wdata_i(acc_wdata_i), .dec_o(dec)
  );

  xstate_regs #(.W(W), .SUP_OK(SUP_OK)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .dec_i(dec), .wdata_i(acc_wdata_i),
    .xcr_o(xcr), .xss_o(xss), .rdata_o(rdata_o), .fault_o(fault_o)
  );

  xstate_mask_gen #(.W(W)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(save_req_i), .sup_i(save_sup_i),
    .rfbm_i(save_rfbm_i), .xcr_i(xcr), .xss_i(xss), .mask_o(mask_o)
  );

  assign feat_en_o = xcr;

  p_fault_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $past(acc_en_i));
  p_user_no_wr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_i && !acc_msr_i && acc_we_i && acc_priv_i != 2'd0) |=> fault_o);
endmodule

// File: tb/xstate_mask_unit_tb.sv
module xstate_mask_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 0, acc_we = 0, acc_msr = 0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  acc_priv = '0;
  logic [7:0]  acc_wdata = '0;
  logic        save_req = 0, save_sup = 0;
  logic [7:0]  save_rfbm = '0;
  logic [7:0]  mask, rdata, feat_en;
  logic        fault;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_xcr = 8'h01, m_xss = 8'h00;

  always #5ns clk = ~clk;

  xstate_mask_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .acc_en_i(acc_en), .acc_we_i(acc_we), .acc_msr_i(acc_msr),
    .acc_addr_i(acc_addr), .acc_priv_i(acc_priv), .acc_wdata_i(acc_wdata),
    .save_req_i(save_req), .save_sup_i(save_sup), .save_rfbm_i(save_rfbm),
    .mask_o(mask), .rdata_o(rdata), .fault_o(fault), .feat_en_o(feat_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, one posedge, sample at next negedge
  task automatic access(input logic msr, input logic we, input logic [15:0] addr,
                        input logic [1:0] priv, input logic [7:0] wd);
    acc_en = 1; acc_msr = msr; acc_we = we; acc_addr = addr; acc_priv = priv; acc_wdata = wd;
    @(negedge clk);
    acc_en = 0; acc_we = 0;
  endtask

  task automatic save(input logic sup, input logic [7:0] rfbm);
    save_req = 1; save_sup = sup; save_rfbm = rfbm;
    @(negedge clk);
    save_req = 0;
  endtask

  task automatic xcr_readback(input string req, input logic [1:0] priv);
    access(0, 0, 16'h0, priv, 8'h00);
    chk({req, " xcr read"}, rdata, m_xcr);
    chk({req, " read fault"}, {7'd0, fault}, 8'd0);
    chk({req, " R8 feat_en"}, feat_en, m_xcr);
  endtask

  task automatic xss_readback(input string req);
    access(1, 0, 16'h0DA0, 2'd0, 8'h00);
    chk({req, " xss read"}, rdata, m_xss);
    chk({req, " read fault"}, {7'd0, fault}, 8'd0);
  endtask

  initial begin
    #1ms;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic exp_f;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 feat_en", feat_en, 8'h01);
    chk("R1 mask", mask, 8'h00);
    chk("R1 fault", {7'd0, fault}, 8'd0);
    chk("R1 rdata", rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);
    xcr_readback("R1", 2'd0);
    xss_readback("R1");

    // R2 R5 R6: sweep all feature control writes at privilege 0
    for (int v = 0; v < 256; v++) begin
      exp_f = (v[0] == 1'b0) || ((v & 8'hF0) != 0);
      access(0, 1, 16'h0, 2'd0, 8'(v));
      chk(exp_f ? "R5/R6 xcr write fault" : "R2 xcr write ok", {7'd0, fault}, {7'd0, exp_f});
      chk("R11 rdata after write", rdata, 8'h00);
      if (!exp_f) m_xcr = 8'(v);
      xcr_readback("R2", 2'(v % 4));
    end

    // R3: unprivileged writes rejected
    access(0, 1, 16'h0, 2'd0, 8'h03); m_xcr = 8'h03;
    for (int p = 1; p < 4; p++) begin
      access(0, 1, 16'h0, 2'(p), 8'h0F);
      chk("R3 priv write fault", {7'd0, fault}, 8'd1);
      xcr_readback("R3", 2'(p));
    end

    // R4: unimplemented index
    for (int i = 1; i < 5; i++) begin
      access(0, 0, 16'(i), 2'd0, 8'h00);
      chk("R4 idx read fault", {7'd0, fault}, 8'd1);
      chk("R4 idx read data", rdata, 8'h00);
      access(0, 1, 16'(i), 2'd0, 8'h07);
      chk("R4 idx write fault", {7'd0, fault}, 8'd1);
      xcr_readback("R4", 2'd0);
    end

    // R7 R6: supervisor register sweep
    for (int v = 0; v < 256; v++) begin
      exp_f = (v & 8'hCF) != 0;
      access(1, 1, 16'h0DA0, 2'd0, 8'(v));
      chk(exp_f ? "R6 xss reserved fault" : "R7 xss write ok", {7'd0, fault}, {7'd0, exp_f});
      if (!exp_f) m_xss = 8'(v);
      xss_readback("R7");
    end
    access(1, 1, 16'h0DA0, 2'd0, 8'h10); m_xss = 8'h10;
    for (int p = 1; p < 4; p++) begin
      access(1, 1, 16'h0DA0, 2'(p), 8'h30);
      chk("R7 xss priv write fault", {7'd0, fault}, 8'd1);
      access(1, 0, 16'h0DA0, 2'(p), 8'h00);
      chk("R7 xss priv read fault", {7'd0, fault}, 8'd1);
      chk("R7 xss priv read data", rdata, 8'h00);
      xss_readback("R7");
    end
    access(1, 1, 16'h0DA1, 2'd0, 8'h30);
    chk("R7 wrong addr write", {7'd0, fault}, 8'd1);
    access(1, 0, 16'h0DA1, 2'd0, 8'h00);
    chk("R7 wrong addr read", {7'd0, fault}, 8'd1);
    xss_readback("R7");
    // R11 single-cycle pulse
    @(negedge clk);
    chk("R11 fault clears", {7'd0, fault}, 8'd0);

    // R9 R10: A only in xcr (bit1), B only in xss (bit4)
    access(0, 1, 16'h0, 2'd0, 8'h03); m_xcr = 8'h03;
    save(0, 8'hFF);
    chk("R9 user A only", mask, 8'h03);
    save(1, 8'hFF);
    chk("R10 sup A and B", mask, 8'h13);

    for (int x = 1; x < 16; x += 2)
      for (int s = 0; s < 4; s++) begin
        access(0, 1, 16'h0, 2'd0, 8'(x)); m_xcr = 8'(x);
        access(1, 1, 16'h0DA0, 2'd0, 8'(s << 4)); m_xss = 8'(s << 4);
        for (int r = 0; r < 4; r++) begin
          logic [7:0] rf;
          rf = (r == 0) ? 8'hFF : (r == 1) ? 8'h00 : (r == 2) ? 8'h25 : 8'hDA;
          save(0, rf);
          chk("R9 user mask", mask, m_xcr & rf);
          @(negedge clk);
          chk("R9 mask hold", mask, m_xcr & rf);
          save(1, rf);
          chk("R10 sup mask", mask, (m_xcr | m_xss) & rf);
        end
      end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule